// File: doc/BRIEF.md
# Paged Program-Space Data Window

This unit sits beside a 16-bit data path and translates each data access into a 24-bit target address. Accesses below 0x8000 go straight to base data memory. Accesses in the upper half of the data space fall into a paged window. A 10-bit read page register steers that window in one of three ways: to extended data memory, to the low 16 bits of a 24-bit program word, or to the upper byte of that word. A 9-bit write page register steers window writes, and writes always stay in data space. A window read while the read page is zero raises an address-error pulse in place of a response.

Reads served from program memory are slow. Outside a repeat loop each one occupies five cycles. Inside a repeat loop with a pointer stepping by ±2, the unit keeps a streak state so that steady iterations cost one cycle each. The first iteration and any iteration next to an interrupt cost five cycles, and the final iteration costs six. Any other step size costs five cycles per iteration.

Requests use a valid/ready handshake: `req_ready` is low for the whole stall of a program read, and a request held during that time waits with its fields stable. The response side has no back-pressure. `rsp_valid` or `addr_trap` pulses for exactly one cycle, in the cycle after acceptance. Page register writes take effect on the next edge, so a request accepted in the same cycle sees the old page value.

Top module: `pgwin_top`

## Requirements
- R1: A read with address bit 15 clear targets base data (`rsp_target` = 0). The address is the 16-bit EA zero-extended to 24 bits, whatever the read page holds, including 0. It costs one cycle.
- R2: A window read with read page bits 9:8 = 11 targets the program upper byte (`rsp_target` = 3). The address is {0, page[7:0], EA[14:0]}, so bit 23 is always 0.
- R3: A window read with read page bits 9:8 = 10 targets the program low word (`rsp_target` = 2). It uses the same address form as R2.
- R4: A window read with read page bit 9 clear and a non-zero page targets extended data (`rsp_target` = 1). The address is {page[8:0], EA[14:0]}, and it costs one cycle.
- R5: In byte mode (`req_byte`=1), `rsp_lane_hi` equals EA bit 0 and address bit 0 follows EA. In word mode, address bit 0 and `rsp_lane_hi` are 0.
- R6: A window read while the read page is 0x000 produces a one-cycle `addr_trap` and no `rsp_valid`.
- R7: After reset the read page reads 0x0001 and the write page reads 0x0000. Readback shows only 10 (read page) and 9 (write page) implemented bits, and the rest read 0.
- R8: Writes never target program memory. A window write goes to extended data at {wpage[8:0], EA[14:0]}, even when the read page is 0 (no trap). A write below 0x8000 goes to base data.
- R9: A program-space read outside a repeat loop keeps `busy` high for 4 cycles after acceptance, so the next request is taken 5 cycles after it.
- R10: In a repeat loop with ±2 stepping, the first program read costs 5 cycles, steady iterations cost 1, and the last iteration costs 6.
- R11: In a repeat loop, an iteration flagged as next to an interrupt costs 5 cycles and the following steady iteration returns to 1. A non-±2 step costs 5 every iteration.
- R12: No request is accepted while `busy` is high. Each accepted request yields exactly one `rsp_valid` or `addr_trap` pulse one cycle later, and no pulse appears otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_ea | input | 16 | Data effective address |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_write | input | 1 | 1 = write, 0 = read |
| rpt_active | input | 1 | Access is an iteration of a repeat loop |
| rpt_last | input | 1 | Final iteration of the loop |
| rpt_step2 | input | 1 | Pointer post-modifies by +2 or -2 |
| rpt_irq | input | 1 | Iteration is next to an interrupt exit or re-entry |
| rpag_we | input | 1 | Load read page from `reg_wdata` |
| wpag_we | input | 1 | Load write page from `reg_wdata` |
| reg_wdata | input | 16 | Page register write data |
| rpag_q | output | 16 | Read page readback |
| wpag_q | output | 16 | Write page readback |
| rsp_valid | output | 1 | Translated access valid (one cycle) |
| rsp_target | output | 2 | 0 base data, 1 extended data, 2 program low word, 3 program upper byte |
| rsp_addr | output | 24 | Translated address |
| rsp_lane_hi | output | 1 | Byte access to the high lane |
| addr_trap | output | 1 | Address-error pulse |
| busy | output | 1 | Program-read stall in progress |

## Verification
The translation is tried with pages from each of the four decode classes (upper byte, low word, extended data, zero) against the same window offsets. A wrong bit 9/8 decode then shows up as a wrong target code rather than merely a wrong address. Low addresses are read with page zero to separate "page ignored" from "trap", and window writes are issued with a program-class or zero read page to show that writes never consult it. Repeat sequences mix first, steady, interrupt-adjacent, last and odd-step iterations, so each cost class is measured by the busy span of its own request. A request raised during a stall measures the wait to acceptance.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
  typedef enum logic [1:0] {
    TGT_DATA = 2'd0,
    TGT_EDS  = 2'd1,
    TGT_PLO  = 2'd2,
    TGT_PHI  = 2'd3
  } tgt_e;
endpackage

// File: rtl/pgwin_page_reg.sv
module pgwin_page_reg #(
  parameter int W     = 10,
  parameter int BUS_W = 16,
  parameter int RST_V = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [BUS_W-1:0] wdata,
  output logic [W-1:0]     q,
  output logic [BUS_W-1:0] rd
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= W'(RST_V);
    else if (we) q <= wdata[W-1:0];
  end
  assign rd = {{(BUS_W-W){1'b0}}, q};
endmodule

// File: rtl/pgwin_decode.sv
module pgwin_decode
  import pgwin_pkg::*;
#(
  parameter int EA_W    = 16,
  parameter int PAGE_W  = 10,
  parameter int WPAGE_W = 9,
  parameter int PA_W    = 24
) (
  input  logic [EA_W-1:0]    ea,
  input  logic               byte_mode,
  input  logic               wr,
  input  logic [PAGE_W-1:0]  rpag,
  input  logic [WPAGE_W-1:0] wpag,
  output tgt_e               tgt,
  output logic [PA_W-1:0]    addr,
  output logic               lane_hi,
  output logic               trap,
  output logic               pgm
);
  localparam int OFF_W      = EA_W - 1;
  localparam int PGM_PAGE_W = PA_W - 1 - OFF_W;
  localparam int EDS_PAGE_W = PAGE_W - 1;

  logic             window;
  logic [EA_W-1:0]  ea_m;
  logic [OFF_W-1:0] off;

  assign window = ea[EA_W-1];
  assign ea_m   = byte_mode ? ea : {ea[EA_W-1:1], 1'b0};
  assign off    = ea_m[OFF_W-1:0];

  always_comb begin
    tgt     = TGT_DATA;
    addr    = {{(PA_W-EA_W){1'b0}}, ea_m};
    lane_hi = byte_mode & ea[0];
    trap    = 1'b0;
    pgm     = 1'b0;
    if (wr) begin
      if (window) begin
        tgt  = TGT_EDS;
        addr = PA_W'({wpag, off});
      end
    end else if (window) begin
      if (rpag == '0) begin
        trap = 1'b1;
        tgt  = TGT_EDS;
      end else if (rpag[PAGE_W-1]) begin
        pgm  = 1'b1;
        tgt  = rpag[PAGE_W-2] ? TGT_PHI : TGT_PLO;
        addr = {1'b0, rpag[PGM_PAGE_W-1:0], off};
      end else begin
        tgt  = TGT_EDS;
        addr = PA_W'({rpag[EDS_PAGE_W-1:0], off});
      end
    end
  end
endmodule

// File: rtl/pgwin_stall.sv
module pgwin_stall #(
  parameter int PGM_CYC  = 5,
  parameter int LAST_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic pgm,
  input  logic rpt_active,
  input  logic rpt_last,
  input  logic rpt_step2,
  input  logic rpt_irq,
  output logic busy
);
  localparam int CNT_W = $clog2(LAST_CYC);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] extra;
  logic             streak;
  logic             loop_fast;

  assign loop_fast = rpt_active & rpt_step2;

  always_comb begin
    if (!pgm)                  extra = '0;
    else if (!loop_fast)       extra = CNT_W'(PGM_CYC - 1);
    else if (rpt_last)         extra = CNT_W'(LAST_CYC - 1);
    else if (rpt_irq || !streak) extra = CNT_W'(PGM_CYC - 1);
    else                       extra = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      streak <= 1'b0;
    end else if (accept) begin
      cnt    <= extra;
      streak <= pgm & loop_fast & ~rpt_last;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/pgwin_top.sv
module pgwin_top
  import pgwin_pkg::*;
#(
  parameter int EA_W     = 16,
  parameter int PAGE_W   = 10,
  parameter int WPAGE_W  = 9,
  parameter int PA_W     = 24,
  parameter int PGM_CYC  = 5,
  parameter int LAST_CYC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [EA_W-1:0] req_ea,
  input  logic            req_byte,
  input  logic            req_write,
  input  logic            rpt_active,
  input  logic            rpt_last,
  input  logic            rpt_step2,
  input  logic            rpt_irq,
  input  logic            rpag_we,
  input  logic            wpag_we,
  input  logic [EA_W-1:0] reg_wdata,
  output logic [EA_W-1:0] rpag_q,
  output logic [EA_W-1:0] wpag_q,
  output logic            rsp_valid,
  output logic [1:0]      rsp_target,
  output logic [PA_W-1:0] rsp_addr,
  output logic            rsp_lane_hi,
  output logic            addr_trap,
  output logic            busy
);
  logic [PAGE_W-1:0]  rpag;
  logic [WPAGE_W-1:0] wpag;
  tgt_e               d_tgt;
  logic [PA_W-1:0]    d_addr;
  logic               d_lane, d_trap, d_pgm;
  logic               accept;

  pgwin_page_reg #(.W(PAGE_W), .BUS_W(EA_W), .RST_V(1)) u_rpag (
    .clk(clk), .rst_n(rst_n), .we(rpag_we), .wdata(reg_wdata),
    .q(rpag), .rd(rpag_q));

  pgwin_page_reg #(.W(WPAGE_W), .BUS_W(EA_W), .RST_V(0)) u_wpag (
    .clk(clk), .rst_n(rst_n), .we(wpag_we), .wdata(reg_wdata),
    .q(wpag), .rd(wpag_q));

  pgwin_decode #(.EA_W(EA_W), .PAGE_W(PAGE_W), .WPAGE_W(WPAGE_W), .PA_W(PA_W)) u_dec (
    .ea(req_ea), .byte_mode(req_byte), .wr(req_write), .rpag(rpag), .wpag(wpag),
    .tgt(d_tgt), .addr(d_addr), .lane_hi(d_lane), .trap(d_trap), .pgm(d_pgm));

  pgwin_stall #(.PGM_CYC(PGM_CYC), .LAST_CYC(LAST_CYC)) u_stall (
    .clk(clk), .rst_n(rst_n), .accept(accept), .pgm(d_pgm),
    .rpt_active(rpt_active), .rpt_last(rpt_last), .rpt_step2(rpt_step2),
    .rpt_irq(rpt_irq), .busy(busy));

  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      addr_trap   <= 1'b0;
      rsp_target  <= TGT_DATA;
      rsp_addr    <= '0;
      rsp_lane_hi <= 1'b0;
    end else begin
      rsp_valid <= accept & ~d_trap;
      addr_trap <= accept & d_trap;
      if (accept) begin
        rsp_target  <= d_tgt;
        rsp_addr    <= d_addr;
        rsp_lane_hi <= d_lane;
      end
    end
  end
endmodule

// File: rtl/pgwin_checker.sv
module pgwin_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [15:0] req_ea,
  input logic        req_write,
  input logic        rpt_active,
  input logic [15:0] rpag_q,
  input logic        rsp_valid,
  input logic [1:0]  rsp_target,
  input logic [23:0] rsp_addr,
  input logic        addr_trap,
  input logic        busy
);
  logic acc;
  assign acc = req_valid & req_ready;

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (rsp_valid ^ addr_trap)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> (!rsp_valid && !addr_trap)); // R12
  AST_TRAP_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    addr_trap |-> ($past(rpag_q) == 16'h0000)); // R6
  AST_WRITE_STAYS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write) |=> !rsp_target[1]); // R8
  AST_PGM_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_target[1]) |-> !rsp_addr[23]); // R2
  AST_PGM_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_ea[15] && !req_write && rpag_q[9] && !rpt_active) |=> busy); // R9
endmodule

bind pgwin_top pgwin_checker u_pgwin_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_ea(req_ea), .req_write(req_write), .rpt_active(rpt_active),
  .rpag_q(rpag_q), .rsp_valid(rsp_valid), .rsp_target(rsp_target),
  .rsp_addr(rsp_addr), .addr_trap(addr_trap), .busy(busy));

// File: tb/pgwin_top_bench.sv
module pgwin_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_byte = 1'b0, req_write = 1'b0;
  logic        rpt_active = 1'b0, rpt_last = 1'b0, rpt_step2 = 1'b0, rpt_irq = 1'b0;
  logic        rpag_we = 1'b0, wpag_we = 1'b0;
  logic [15:0] req_ea = '0, reg_wdata = '0;
  logic        req_ready, rsp_valid, rsp_lane_hi, addr_trap, busy;
  logic [15:0] rpag_q, wpag_q;
  logic [1:0]  rsp_target;
  logic [23:0] rsp_addr;

  typedef struct packed {
    logic        trap;
    logic [1:0]  tgt;
    logic [23:0] addr;
    logic        lane;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0, n_fail = 0, n_push = 0, n_seen = 0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwin_top u_pgwin_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_byte(req_byte), .req_write(req_write),
    .rpt_active(rpt_active), .rpt_last(rpt_last), .rpt_step2(rpt_step2),
    .rpt_irq(rpt_irq), .rpag_we(rpag_we), .wpag_we(wpag_we),
    .reg_wdata(reg_wdata), .rpag_q(rpag_q), .wpag_q(wpag_q),
    .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_addr(rsp_addr),
    .rsp_lane_hi(rsp_lane_hi), .addr_trap(addr_trap), .busy(busy));

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && (rsp_valid || addr_trap)) begin
      n_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected response", {addr_trap, rsp_target, rsp_addr, rsp_lane_hi}, 0);
      end else begin
        exp_t  e;
        exp_t  a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = e.trap ? '{trap: addr_trap & ~rsp_valid, tgt: 2'd0, addr: 24'd0, lane: 1'b0}
                   : '{trap: addr_trap | ~rsp_valid, tgt: rsp_target, addr: rsp_addr, lane: rsp_lane_hi};
        check(a == e, t, a, e);
      end
    end
  end

  task automatic wr_page(input bit rd_page, input logic [15:0] v);
    reg_wdata = v;
    rpag_we   = rd_page;
    wpag_we   = ~rd_page;
    @(negedge clk);
    rpag_we = 1'b0;
    wpag_we = 1'b0;
  endtask

  // ebusy/ewait < 0 skip that measurement
  task automatic do_req(input logic [15:0] ea, input logic byt, input logic wr,
                        input logic ra, input logic rl, input logic s2, input logic ri,
                        input logic et, input logic [1:0] etg, input logic [23:0] eaddr,
                        input logic el, input int ebusy, input int ewait, input string tag);
    int waited;
    int n;
    req_ea = ea; req_byte = byt; req_write = wr;
    rpt_active = ra; rpt_last = rl; rpt_step2 = s2; rpt_irq = ri;
    req_valid = 1'b1;
    waited = 0;
    while (!req_ready) begin
      @(negedge clk);
      waited++;
    end
    exp_q.push_back('{trap: et, tgt: et ? 2'd0 : etg, addr: et ? 24'd0 : eaddr, lane: et ? 1'b0 : el});
    tag_q.push_back(tag);
    n_push++;
    @(negedge clk);
    req_valid = 1'b0;
    if (ewait >= 0) check(waited == ewait, {tag, " wait"}, waited, ewait);
    if (ebusy >= 0) begin
      n = 0;
      while (busy) begin
        n++;
        @(negedge clk);
      end
      check(n == ebusy, {tag, " busy"}, n, ebusy);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check(rpag_q == 16'h0001, "R7 read page reset", rpag_q, 16'h0001);
    check(wpag_q == 16'h0000, "R7 write page reset", wpag_q, 0);
    check(!busy && req_ready, "R12 idle after reset", busy, 0);

    // R1 / R5 base data
    do_req(16'h1235, 0,0, 0,0,0,0, 0, 2'd0, 24'h001234, 0, 0, 0, "R1 R5 word low read");
    do_req(16'h0567, 1,0, 0,0,0,0, 0, 2'd0, 24'h000567, 1, 0, 0, "R1 R5 byte low read");
    wr_page(1, 16'h0000);
    do_req(16'h0100, 0,0, 0,0,0,0, 0, 2'd0, 24'h000100, 0, 0, 0, "R1 page zero ignored");
    // R6 trap
    do_req(16'h8000, 0,0, 0,0,0,0, 1, 2'd0, 24'h0, 0, 0, 0, "R6 page zero trap");
    // R8 window write with read page 0: no trap
    do_req(16'h8044, 0,1, 0,0,0,0, 0, 2'd1, 24'h000044, 0, 0, 0, "R8 write page zero window");

    // R7 implemented widths
    wr_page(1, 16'hFFFF);
    check(rpag_q == 16'h03FF, "R7 read page width", rpag_q, 16'h03FF);
    wr_page(0, 16'hFFFF);
    check(wpag_q == 16'h01FF, "R7 write page width", wpag_q, 16'h01FF);

    // R2 / R9 upper byte
    do_req(16'h8002, 0,0, 0,0,0,0, 0, 2'd3, 24'h7F8002, 0, 4, 0, "R2 R9 upper byte read");
    // R3 / R5 low word
    wr_page(1, 16'h02A5);
    do_req(16'hC001, 1,0, 0,0,0,0, 0, 2'd2, 24'h52C001, 1, 4, 0, "R3 R5 low word byte");
    do_req(16'hC001, 0,0, 0,0,0,0, 0, 2'd2, 24'h52C000, 0, 4, 0, "R3 R5 low word word");
    // R8 writes with program-class read page
    do_req(16'h9000, 0,1, 0,0,0,0, 0, 2'd1, 24'hFF9000, 0, 0, 0, "R8 window write");
    do_req(16'h0042, 0,1, 0,0,0,0, 0, 2'd0, 24'h000042, 0, 0, 0, "R8 low write");
    // R4 extended data
    wr_page(1, 16'h0155);
    do_req(16'h8010, 0,0, 0,0,0,0, 0, 2'd1, 24'hAA8010, 0, 0, 0, "R4 extended read");

    // R10 repeat loop
    wr_page(1, 16'h0212);
    do_req(16'h8000, 0,0, 1,0,1,0, 0, 2'd2, 24'h090000, 0, 4, 0, "R10 first iteration");
    do_req(16'h8002, 0,0, 1,0,1,0, 0, 2'd2, 24'h090002, 0, 0, 0, "R10 steady iteration");
    do_req(16'h8004, 0,0, 1,0,1,0, 0, 2'd2, 24'h090004, 0, 0, 0, "R10 steady iteration 2");
    do_req(16'h8006, 0,0, 1,1,1,0, 0, 2'd2, 24'h090006, 0, 5, 0, "R10 last iteration");
    // R11 interrupt-adjacent
    do_req(16'h8008, 0,0, 1,0,1,0, 0, 2'd2, 24'h090008, 0, 4, 0, "R11 loop first");
    do_req(16'h800A, 0,0, 1,0,1,0, 0, 2'd2, 24'h09000A, 0, 0, 0, "R11 loop steady");
    do_req(16'h800C, 0,0, 1,0,1,1, 0, 2'd2, 24'h09000C, 0, 4, 0, "R11 interrupt iteration");
    do_req(16'h800E, 0,0, 1,0,1,0, 0, 2'd2, 24'h09000E, 0, 0, 0, "R11 steady after interrupt");
    do_req(16'h8010, 0,0, 1,1,1,0, 0, 2'd2, 24'h090010, 0, 5, 0, "R11 loop last");
    // R11 odd step
    do_req(16'h8020, 0,0, 1,0,0,0, 0, 2'd2, 24'h090020, 0, 4, 0, "R11 odd step 1");
    do_req(16'h8024, 0,0, 1,0,0,0, 0, 2'd2, 24'h090024, 0, 4, 0, "R11 odd step 2");

    // R12 request raised during stall
    do_req(16'h8030, 0,0, 0,0,0,0, 0, 2'd2, 24'h090030, 0, -1, 0, "R12 stalling read");
    do_req(16'h0030, 0,1, 0,0,0,0, 0, 2'd0, 24'h000030, 0, 0, 4, "R12 held request");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0 && n_seen == n_push, "R12 response count", n_seen, n_push);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule